// File: doc/BRIEF.md
# Wishbone Control/Status Register Bank

This block is a bank of control and status registers that answers on a Wishbone slave port. Each register has an access type fixed by a parameter. The five types are read/write, write-only, read-only, clear-on-read and constant. Registers that software can write drive their value continuously onto a per-register output lane toward the user function. Registers that software reads take their value from a per-register input lane coming back from that function.

The bank sits at a base address set by a parameter. A register answers when the bus address equals the base plus that register's own offset. The offsets need not be contiguous, and any address that matches no register gets no acknowledge. The address width, data width, register count, offsets, access types and reset values are all parameters. The reset polarity is a single parameter that applies to the whole bank.

The address decode builds a one-hot match vector. A priority-encoded select stage turns that vector into the read data of the chosen register. Single-beat cycles are supported. Burst cycles are also supported: the master holds CYC and presents a new address after each acknowledge.

Top module: `regbank_wb`

## Requirements
- R1: While reset is active (active level set by `RST_ACTIVE_HIGH`, default active-low), every register loads its own reset value, `wb_ack_o` is 0 and `wb_dat_o` is 0. After reset, each write-only and read/write register shows its reset value on its `reg_out_o` lane.
- R2: A register is selected only when `wb_adr_i` equals `BASE` plus that register's offset. At most one register is selected for any address.
- R3: When CYC and STB are high, the address selects a register and no acknowledge is pending, `wb_ack_o` rises on the next clock edge and stays high for exactly one cycle. An address that selects no register is never acknowledged. `wb_dat_o` is 0 whenever `wb_ack_o` is 0.
- R4: A write to a read/write register replaces its full data width on the acknowledging edge, whatever the value of `wb_sel_i` (including all zeros). A later read returns the written value.
- R5: A write to a write-only register updates its `reg_out_o` lane on the acknowledging edge. Reads of that register are acknowledged and return 0.
- R6: A read-only register samples its `hw_in_i` lane on every clock, and a read returns the sampled value. Writes to it are acknowledged and have no effect.
- R7: A clear-on-read register ORs its `hw_in_i` lane into its value on every clock. A read returns the current value and zeroes the register on the acknowledging edge, but input bits that are high on that edge stay set. Writes to it are acknowledged and have no effect.
- R8: A constant register always reads its reset value. Writes to it are acknowledged and have no effect.
- R9: Within a single CYC, several consecutive beats to different registers, mixing reads and writes, are each acknowledged once and each take effect as a single beat would.
- R10: Lanes of `reg_out_o` that belong to read-only, clear-on-read or constant registers are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bank clock |
| rst_i | input | 1 | Synchronous reset, polarity set by `RST_ACTIVE_HIGH` |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Beat strobe |
| wb_we_i | input | 1 | 1 = write beat, 0 = read beat |
| wb_adr_i | input | AW | Beat address |
| wb_dat_i | input | DW | Write data |
| wb_sel_i | input | DW/8 | Byte selects (no effect on writes) |
| wb_dat_o | output | DW | Read data, valid while `wb_ack_o` is high, else 0 |
| wb_ack_o | output | 1 | Beat acknowledge |
| hw_in_i | input | NREG*DW | Per-register input lanes; register i uses bits [i*DW +: DW] |
| reg_out_o | output | NREG*DW | Per-register output lanes; register i uses bits [i*DW +: DW] |

## Verification
Every register effect lands on the clock edge that raises `wb_ack_o`, one edge after the request is presented. The bench therefore drives a beat at a falling edge and samples at each following falling edge until it sees the acknowledge. At that point it compares the read data, and also the output lanes changed by a write. A read-only register needs one clock edge to pick up a new input value, so the bench changes those inputs only between beats and lets one idle edge pass before the next beat. For an address outside the bank, the bench waits four edges and expects neither an acknowledge nor nonzero read data.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    ACC_RO    = 3'd0,
    ACC_WO    = 3'd1,
    ACC_RW    = 3'd2,
    ACC_COR   = 3'd3,
    ACC_CONST = 3'd4
  } acc_e;

  // Absolute bus address of a register: bank base plus its offset.
  function automatic logic [31:0] reg_address(logic [31:0] base, logic [31:0] off);
    return base + off;
  endfunction

  // Types whose value software sets and which drive an output lane.
  function automatic logic acc_writable(logic [2:0] t);
    return (t == ACC_WO) || (t == ACC_RW);
  endfunction

  // Types whose value is visible to a bus read.
  function automatic logic acc_readable(logic [2:0] t);
    return t != ACC_WO;
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int AW   = 8,
  parameter int NREG = 8,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [NREG*AW-1:0] OFFS = '0
) (
  input  logic            clk_i,
  input  logic            rst_act_i,
  input  logic [AW-1:0]   adr_i,
  output logic [NREG-1:0] hit_o,
  output logic            hit_any_o
);
  import regbank_pkg::*;

  for (genvar i = 0; i < NREG; i++) begin : g_match
    localparam logic [AW-1:0] MATCH =
      AW'(reg_address(32'(BASE), 32'(OFFS[i*AW +: AW])));
    assign hit_o[i] = (adr_i == MATCH);
  end

  assign hit_any_o = |hit_o;

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_act_i)
    $onehot0(hit_o)); // R2

endmodule

// File: rtl/regbank_cell.sv
module regbank_cell #(
  parameter int DW = 16,
  parameter logic [2:0] ACC = 3'd2,
  parameter logic [DW-1:0] INIT = '0
) (
  input  logic          clk_i,
  input  logic          rst_act_i,
  input  logic          wr_en_i,
  input  logic          rd_clr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] hw_i,
  output logic [DW-1:0] rd_o,
  output logic [DW-1:0] out_o
);
  import regbank_pkg::*;

  localparam logic WRITABLE = acc_writable(ACC);
  localparam logic READABLE = acc_readable(ACC);

  logic [DW-1:0] val_q;
  logic [DW-1:0] val_d;

  always_comb begin
    val_d = val_q;
    case (ACC)
      ACC_RO:    val_d = hw_i;
      ACC_WO,
      ACC_RW:    if (wr_en_i) val_d = wdata_i;
      ACC_COR:   val_d = (rd_clr_i ? '0 : val_q) | hw_i;
      default:   val_d = INIT;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_act_i) val_q <= INIT;
    else           val_q <= val_d;
  end

  assign rd_o  = READABLE ? val_q : '0;
  assign out_o = WRITABLE ? val_q : '0;

  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (rst_act_i)
    (WRITABLE && !wr_en_i) |=> $stable(out_o)); // R4

  AST_COR_CLEAR: assert property (@(posedge clk_i) disable iff (rst_act_i)
    ((ACC == ACC_COR) && rd_clr_i && (hw_i == '0)) |=> (rd_o == '0)); // R7

endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic [NREG-1:0]    sel_i,
  input  logic [NREG*DW-1:0] data_i,
  output logic [DW-1:0]      dout_o
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [IW-1:0] idx;
  logic          found;

  // Priority encoder: lowest selected register wins.
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (sel_i[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign dout_o = found ? data_i[idx*DW +: DW] : '0;

endmodule

// File: rtl/regbank_wb.sv
module regbank_wb #(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter logic RST_ACTIVE_HIGH = 1'b0,
  parameter logic [AW-1:0] BASE = 8'h40,
  parameter logic [NREG*AW-1:0] OFFS =
    {8'd12, 8'd10, 8'd9, 8'd8, 8'd3, 8'd2, 8'd1, 8'd0},
  parameter logic [NREG*3-1:0] ACCS =
    {3'd2, 3'd4, 3'd3, 3'd0, 3'd0, 3'd1, 3'd2, 3'd2},
  parameter logic [NREG*DW-1:0] INITS =
    {16'hF00F, 16'h5A5A, 16'h8001, 16'h0000, 16'h0000, 16'h1111, 16'h003C, 16'hA5A5}
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wb_cyc_i,
  input  logic               wb_stb_i,
  input  logic               wb_we_i,
  input  logic [AW-1:0]      wb_adr_i,
  input  logic [DW-1:0]      wb_dat_i,
  input  logic [DW/8-1:0]    wb_sel_i,
  output logic [DW-1:0]      wb_dat_o,
  output logic               wb_ack_o,
  input  logic [NREG*DW-1:0] hw_in_i,
  output logic [NREG*DW-1:0] reg_out_o
);

  logic              rst_act;
  logic [NREG-1:0]   hit;
  logic              hit_any;
  logic              req;
  logic              accept;
  logic [NREG*DW-1:0] rd_flat;
  logic [DW-1:0]     rd_sel;
  logic              ack_q;
  logic [DW-1:0]     dat_q;

  assign rst_act = RST_ACTIVE_HIGH ? rst_i : ~rst_i;
  assign req     = wb_cyc_i & wb_stb_i;
  assign accept  = req & hit_any & ~ack_q;

  regbank_decode #(
    .AW(AW), .NREG(NREG), .BASE(BASE), .OFFS(OFFS)
  ) u_decode (
    .clk_i(clk_i), .rst_act_i(rst_act), .adr_i(wb_adr_i),
    .hit_o(hit), .hit_any_o(hit_any)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic wr_en;
    logic rd_clr;
    assign wr_en  = accept &  wb_we_i & hit[i];
    assign rd_clr = accept & ~wb_we_i & hit[i];

    regbank_cell #(
      .DW(DW), .ACC(ACCS[i*3 +: 3]), .INIT(INITS[i*DW +: DW])
    ) u_cell (
      .clk_i(clk_i), .rst_act_i(rst_act),
      .wr_en_i(wr_en), .rd_clr_i(rd_clr),
      .wdata_i(wb_dat_i), .hw_i(hw_in_i[i*DW +: DW]),
      .rd_o(rd_flat[i*DW +: DW]), .out_o(reg_out_o[i*DW +: DW])
    );
  end

  regbank_rdmux #(.DW(DW), .NREG(NREG)) u_rdmux (
    .sel_i(hit), .data_i(rd_flat), .dout_o(rd_sel)
  );

  always_ff @(posedge clk_i) begin
    if (rst_act) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= accept;
      dat_q <= (accept && !wb_we_i) ? rd_sel : '0;
    end
  end

  assign wb_ack_o = ack_q;
  assign wb_dat_o = dat_q;

  AST_NO_ACK_OUTSIDE: assert property (@(posedge clk_i) disable iff (rst_act)
    (req && !hit_any) |=> !wb_ack_o); // R3

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (rst_act)
    (req && hit_any && !wb_ack_o) |=> wb_ack_o); // R3

  AST_DAT_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_act)
    !wb_ack_o |-> (wb_dat_o == '0)); // R3

  AST_SEL_NO_STALL: assert property (@(posedge clk_i) disable iff (rst_act)
    (req && wb_we_i && hit_any && !wb_ack_o && (wb_sel_i == '0)) |=> wb_ack_o); // R4

  AST_ACK_ONE_BEAT: assert property (@(posedge clk_i) disable iff (rst_act)
    wb_ack_o |=> !wb_ack_o); // R9

endmodule

// File: tb/regbank_wb_tb.sv
`timescale 1ns/1ps
module regbank_wb_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NREG = 8;
  localparam logic [AW-1:0] TB_BASE = 8'h40;

  // Bench view of the configuration: type 0 RO, 1 WO, 2 RW, 3 COR, 4 CONST.
  function automatic int t_off(int i);
    case (i) 0: return 0; 1: return 1; 2: return 2; 3: return 3;
      4: return 8; 5: return 9; 6: return 10; default: return 12; endcase
  endfunction
  function automatic int t_type(int i);
    case (i) 2: return 1; 3, 4: return 0; 5: return 3; 6: return 4;
      default: return 2; endcase
  endfunction
  function automatic logic [DW-1:0] t_init(int i);
    case (i) 0: return 16'hA5A5; 1: return 16'h003C; 2: return 16'h1111;
      5: return 16'h8001; 6: return 16'h5A5A; 7: return 16'hF00F;
      default: return 16'h0000; endcase
  endfunction
  function automatic logic [AW-1:0] t_addr(int i);
    return AW'(int'(TB_BASE) + t_off(i));
  endfunction
  function automatic logic [AW-1:0] t_miss(int k);
    case (k % 6) 0: return 8'h44; 1: return 8'h47; 2: return 8'h4B;
      3: return 8'h4D; 4: return 8'h3F; default: return 8'h00; endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 0, stb = 0, we = 0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] wdat = '0;
  logic [DW/8-1:0] sel = '0;
  logic [DW-1:0] rdat;
  logic ack;
  logic [NREG*DW-1:0] hw = '0;
  logic [NREG*DW-1:0] rout;

  logic [DW-1:0] mdl [NREG];
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  regbank_wb u_dut (
    .clk_i(clk), .rst_i(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_sel_i(sel), .wb_dat_o(rdat),
    .wb_ack_o(ack), .hw_in_i(hw), .reg_out_o(rout)
  );

  function automatic logic [DW-1:0] exp_read(int i);
    return (t_type(i) == 1) ? '0 : mdl[i];
  endfunction
  function automatic logic [DW-1:0] exp_out(int i);
    return (t_type(i) == 1 || t_type(i) == 2) ? mdl[i] : '0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // One beat, called at a falling edge. keep=1 leaves CYC high for a burst.
  task automatic beat(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [DW/8-1:0] s, input bit keep,
                      output bit got, output logic [DW-1:0] rd);
    cyc = 1; stb = 1; we = w; adr = a; wdat = d; sel = s;
    got = 0; rd = '0;
    for (int n = 0; n < 4 && !got; n++) begin
      @(posedge clk); @(negedge clk);
      if (ack) begin got = 1; rd = rdat; end
      else if (rdat !== '0) chk("R3 idle data", 32'(rdat), 32'h0);
    end
    if (!keep) begin
      cyc = 0; stb = 0; we = 0;
      @(negedge clk);
    end
  endtask

  // Beat to register i with model update and checks.
  task automatic reg_beat(input int i, input logic w, input logic [DW-1:0] d,
                          input logic [DW/8-1:0] s, input bit keep, input string req);
    bit got; logic [DW-1:0] rd; logic [DW-1:0] e;
    e = exp_read(i);
    beat(w, t_addr(i), d, s, keep, got, rd);
    chk({req, " ack"}, 32'(got), 32'h1);
    if (!w) begin
      chk({req, " read data"}, 32'(rd), 32'(e));
      if (t_type(i) == 3) mdl[i] = hw[i*DW +: DW];
    end else begin
      if (t_type(i) == 1 || t_type(i) == 2) mdl[i] = d;
      for (int k = 0; k < NREG; k++)
        chk({req, " output lane"}, 32'(rout[k*DW +: DW]), 32'(exp_out(k)));
    end
  endtask

  task automatic set_ro(input int i, input logic [DW-1:0] v);
    hw[i*DW +: DW] = v; mdl[i] = v;
    @(negedge clk);
  endtask

  initial begin
    bit got; logic [DW-1:0] rd; int r;
    r = $urandom(32'h00C0FFEE);
    for (int i = 0; i < NREG; i++) mdl[i] = t_init(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ack in reset", 32'(ack), 32'h0);
    chk("R1 data in reset", 32'(rdat), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NREG; k++)
      chk("R1 R10 lane after reset", 32'(rout[k*DW +: DW]), 32'(exp_out(k)));
    mdl[3] = '0; mdl[4] = '0;
    reg_beat(0, 0, 0, 2'b11, 0, "R1 rw reset value");
    reg_beat(5, 0, 0, 2'b11, 0, "R1 R7 cor reset value");
    reg_beat(5, 0, 0, 2'b11, 0, "R7 cor cleared");
    reg_beat(6, 0, 0, 2'b11, 0, "R8 const read");

    // R4: zero byte selects still write the full width
    reg_beat(1, 1, 16'hBEEF, 2'b00, 0, "R4 sel zero write");
    reg_beat(1, 0, 0, 2'b00, 0, "R4 readback");
    // R5: write-only
    reg_beat(2, 1, 16'h7E81, 2'b11, 0, "R5 wo write");
    reg_beat(2, 0, 0, 2'b11, 0, "R5 wo read zero");
    // R6: read-only sampling and ignored write
    set_ro(3, 16'h1234);
    reg_beat(3, 0, 0, 2'b11, 0, "R6 ro sample");
    reg_beat(3, 1, 16'hFFFF, 2'b11, 0, "R6 R10 ro write ignored");
    reg_beat(3, 0, 0, 2'b11, 0, "R6 ro after write");
    // R8: constant write ignored
    reg_beat(6, 1, 16'h0000, 2'b11, 0, "R8 const write");
    reg_beat(6, 0, 0, 2'b11, 0, "R8 const after write");
    // R7: set wins over clear, sticky accumulate, write ignored
    hw[5*DW +: DW] = 16'h0004; mdl[5] = mdl[5] | 16'h0004; @(negedge clk);
    reg_beat(5, 0, 0, 2'b11, 0, "R7 cor set");
    reg_beat(5, 0, 0, 2'b11, 0, "R7 cor set wins clear");
    hw[5*DW +: DW] = 16'h0000; @(negedge clk);
    reg_beat(5, 0, 0, 2'b11, 0, "R7 cor after set drop");
    reg_beat(5, 1, 16'hFFFF, 2'b11, 0, "R7 cor write");
    reg_beat(5, 0, 0, 2'b11, 0, "R7 cor write ignored");
    // R3 and R2: addresses outside the bank
    for (int k = 0; k < 6; k++) begin
      beat(k[0], t_miss(k), 16'hFFFF, 2'b11, 0, got, rd);
      chk("R2 R3 miss no ack", 32'(got), 32'h0);
      chk("R3 miss data zero", 32'(rd), 32'h0);
    end
    for (int k = 0; k < NREG; k++)
      chk("R3 miss no effect", 32'(rout[k*DW +: DW]), 32'(exp_out(k)));
    // R9: burst of writes and reads in one cycle
    reg_beat(0, 1, 16'h0102, 2'b01, 1, "R9 burst w0");
    reg_beat(7, 1, 16'h0304, 2'b10, 1, "R9 burst w7");
    reg_beat(2, 1, 16'h0506, 2'b11, 1, "R9 burst w2");
    reg_beat(0, 0, 0, 2'b11, 1, "R9 burst r0");
    reg_beat(7, 0, 0, 2'b11, 1, "R9 burst r7");
    reg_beat(6, 0, 0, 2'b11, 0, "R9 burst r6");

    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      int pick; logic w; logic [DW-1:0] d; logic [DW/8-1:0] s;
      pick = int'($urandom % 11);
      w = 1'($urandom % 2);
      d = DW'($urandom);
      s = 2'($urandom);
      if (pick == 10) begin
        set_ro(3 + int'($urandom % 2), DW'($urandom));
      end else if (pick >= NREG) begin
        beat(w, t_miss(int'($urandom % 6)), d, s, 0, got, rd);
        chk("R3 random miss", 32'(got), 32'h0);
      end else begin
        reg_beat(pick, w, d, s, 0, "R2 random beat");
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_900_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule